// File: doc/BRIEF.md
# Coin-Operated Gum Vendor Controller

This block is the decision logic of a single-slot gum dispenser that charges 15 cents per item. The coin sensor in front of it raises one of two single-cycle pulses for each coin it recognises: one for a nickel (5 cents) and one for a dime (10 cents). The controller keeps a running credit of 0, 5 or 10 cents. When a coin brings the credit to 15 cents or more, it raises a one-cycle release strobe for the dispensing mechanism and returns to zero credit. No change is paid, so any excess above the price is forfeited.

The machine has three states. CREDIT_0 holds no credit. CREDIT_5 holds one nickel's worth. CREDIT_10 holds a dime or two nickels. The named transitions are:
- ADD_NICKEL_0: CREDIT_0 to CREDIT_5.
- ADD_DIME_0: CREDIT_0 to CREDIT_10.
- ADD_NICKEL_5: CREDIT_5 to CREDIT_10.
- VEND_EXACT_DIME: CREDIT_5 to CREDIT_0, with release.
- VEND_EXACT_NICKEL: CREDIT_10 to CREDIT_0, with release.
- VEND_OVERPAY: CREDIT_10 to CREDIT_0, with release, when a dime arrives.
- HOLD: stay in the current state on any cycle without a legal coin.

The release strobe comes from a flip-flop. It is high for the whole cycle that follows the clock edge that accepted the paying coin, and it does not depend combinationally on the coin inputs.

Top module: `gum_vendor`

## Requirements
- R1: With `rst` high at a rising edge, the credit becomes 0 and `vend_out` is 0 during the following cycle, whatever the coin inputs are.
- R2: A nickel (`nickel_in`=1, `dime_in`=0) accepted at 0 credit moves the credit to 5 cents without a release.
- R3: A dime (`dime_in`=1, `nickel_in`=0) accepted at 0 credit moves the credit to 10 cents without a release.
- R4: A coin that makes the credit exactly 15 cents releases the item and clears the credit. This covers nickel-nickel-nickel, nickel-dime and dime-nickel.
- R5: A dime accepted at 10 cents of credit (20 cents total) releases the item and clears the credit. The extra 5 cents is not carried forward.
- R6: `vend_out` is 1 for exactly the one cycle after the edge that accepted the paying coin, and 0 in all other cycles.
- R7: A cycle with neither detect signal high leaves the credit unchanged.
- R8: A cycle with both `nickel_in` and `dime_in` high is illegal and is ignored: the credit is unchanged and no release occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| nickel_in | input | 1 | Single-cycle pulse: a 5-cent coin was detected |
| dime_in | input | 1 | Single-cycle pulse: a 10-cent coin was detected |
| vend_out | output | 1 | Registered one-cycle release strobe |

## Verification
The bench drives every ordering of coins that reaches 15 or 20 cents. A design that wrongly carried the overpaid 5 cents forward would release one coin too early on the next purchase, and one that used a greater-than test instead of greater-or-equal would miss the exact-price release. Simultaneous nickel and dime pulses are applied at every credit level. A design that decoded either bit alone would gain credit or release early, and the bench sees this in the timing of later releases. Idle gaps, a reset while credit is held, and back-to-back purchases check that the strobe lasts one cycle and lines up with the edge that accepted the coin.

// File: rtl/gum_vendor_pkg.sv
package gum_vendor_pkg;

    localparam int PRICE_CENTS  = 15;
    localparam int NICKEL_CENTS = 5;
    localparam int DIME_CENTS   = 10;
    localparam int CENTS_W      = $clog2(PRICE_CENTS + DIME_CENTS + 1);

    typedef enum logic [1:0] {
        CREDIT_0  = 2'd0,
        CREDIT_5  = 2'd1,
        CREDIT_10 = 2'd2
    } credit_e;

    typedef enum logic [1:0] {
        COIN_NONE   = 2'd0,
        COIN_NICKEL = 2'd1,
        COIN_DIME   = 2'd2,
        COIN_BAD    = 2'd3
    } coin_e;

    function automatic logic [CENTS_W-1:0] credit_cents(credit_e c);
        logic [CENTS_W-1:0] v;
        unique case (c)
            CREDIT_0:  v = CENTS_W'(0);
            CREDIT_5:  v = CENTS_W'(NICKEL_CENTS);
            CREDIT_10: v = CENTS_W'(DIME_CENTS);
            default:   v = CENTS_W'(0);
        endcase
        return v;
    endfunction

    function automatic logic [CENTS_W-1:0] coin_cents(coin_e k);
        logic [CENTS_W-1:0] v;
        unique case (k)
            COIN_NICKEL: v = CENTS_W'(NICKEL_CENTS);
            COIN_DIME:   v = CENTS_W'(DIME_CENTS);
            default:     v = CENTS_W'(0);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/coin_classifier.sv
module coin_classifier
    import gum_vendor_pkg::*;
(
    input  logic  nickel_det,
    input  logic  dime_det,
    output coin_e coin
);

    always_comb begin
        unique case ({dime_det, nickel_det})
            2'b01:   coin = COIN_NICKEL;
            2'b10:   coin = COIN_DIME;
            2'b11:   coin = COIN_BAD;
            default: coin = COIN_NONE;
        endcase
    end

endmodule

// File: rtl/credit_fsm.sv
module credit_fsm
    import gum_vendor_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  coin_e   coin,
    output credit_e state_q,
    output logic    vend_next
);

    credit_e state_d;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= CREDIT_0;
        else     state_q <= state_d;
    end

    // next-state and release decision
    always_comb begin
        state_d   = state_q;
        vend_next = 1'b0;
        unique case (state_q)
            CREDIT_0: begin
                if (coin == COIN_NICKEL)    state_d = CREDIT_5;   // ADD_NICKEL_0
                else if (coin == COIN_DIME) state_d = CREDIT_10;  // ADD_DIME_0
            end
            CREDIT_5: begin
                if (coin == COIN_NICKEL) begin
                    state_d = CREDIT_10;                          // ADD_NICKEL_5
                end else if (coin == COIN_DIME) begin
                    state_d   = CREDIT_0;                         // VEND_EXACT_DIME
                    vend_next = 1'b1;
                end
            end
            CREDIT_10: begin
                if (coin == COIN_NICKEL || coin == COIN_DIME) begin
                    state_d   = CREDIT_0;                         // VEND_EXACT_NICKEL / VEND_OVERPAY
                    vend_next = 1'b1;
                end
            end
            default: begin
                state_d = CREDIT_0;
            end
        endcase
    end

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (coin == COIN_NONE) |=> $stable(state_q));

    // R8
    illegal_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (coin == COIN_BAD) |=> ($stable(state_q) && !$past(vend_next)));

    // R4
    vend_threshold_chk: assert property (@(posedge clk) disable iff (rst)
        vend_next |-> ((credit_cents(state_q) + coin_cents(coin)) >= CENTS_W'(PRICE_CENTS)));

    // R5
    overpay_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == CREDIT_10 && coin == COIN_DIME) |=> (state_q == CREDIT_0));

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (state_q == CREDIT_0));

endmodule

// File: rtl/vend_strobe.sv
module vend_strobe (
    input  logic clk,
    input  logic rst,
    input  logic vend_next,
    output logic vend_q
);

    // output register
    always_ff @(posedge clk) begin
        if (rst) vend_q <= 1'b0;
        else     vend_q <= vend_next;
    end

    // R6
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        vend_q |=> !vend_q);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        rst |=> !vend_q);

endmodule

// File: rtl/gum_vendor.sv
module gum_vendor
    import gum_vendor_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic nickel_in,
    input  logic dime_in,
    output logic vend_out
);

    coin_e   coin;
    credit_e credit;
    logic    vend_next;

    coin_classifier u_class (
        .nickel_det (nickel_in),
        .dime_det   (dime_in),
        .coin       (coin)
    );

    credit_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .coin      (coin),
        .state_q   (credit),
        .vend_next (vend_next)
    );

    vend_strobe u_strobe (
        .clk       (clk),
        .rst       (rst),
        .vend_next (vend_next),
        .vend_q    (vend_out)
    );

    // R6
    vend_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
        vend_out |-> (credit == CREDIT_0));

endmodule

// File: tb/sim_gum_vendor.sv
`timescale 1ns/1ps
module sim_gum_vendor;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic nickel_in = 1'b0;
    logic dime_in = 1'b0;
    logic vend_out;

    int vectors = 0;
    int miscompares = 0;
    int model_credit = 0;
    logic model_vend = 1'b0;
    bit done = 0;

    always #2 clk = ~clk;

    gum_vendor u0 (
        .clk       (clk),
        .rst       (rst),
        .nickel_in (nickel_in),
        .dime_in   (dime_in),
        .vend_out  (vend_out)
    );

    // one clock: drive at negedge, model at posedge, compare at next negedge
    task automatic step(input logic r, input logic n, input logic d, input string tag);
        rst = r; nickel_in = n; dime_in = d;
        @(posedge clk);
        if (r) begin
            model_credit = 0;
            model_vend = 1'b0;
        end else if (n ^ d) begin
            model_credit = model_credit + (n ? 5 : 10);
            if (model_credit >= 15) begin
                model_vend = 1'b1;
                model_credit = 0;
            end else begin
                model_vend = 1'b0;
            end
        end else begin
            model_vend = 1'b0;
        end
        @(negedge clk);
        vectors++;
        if (vend_out !== model_vend) begin
            miscompares++;
            $display("FAIL %s: vend_out=%b expected=%b (model credit %0d)",
                     tag, vend_out, model_vend, model_credit);
        end
    endtask

    task automatic idle(input int k, input string tag);
        for (int i = 0; i < k; i++) step(1'b0, 1'b0, 1'b0, tag);
    endtask

    initial begin
        @(negedge clk);
        step(1'b1, 1'b0, 1'b0, "R1 reset");
        step(1'b1, 1'b1, 1'b1, "R1 reset with coins");
        step(1'b0, 1'b0, 1'b0, "R1 idle after reset");

        // R2 then R4: three nickels
        step(1'b0, 1'b1, 1'b0, "R2 nickel at 0");
        idle(2, "R7 hold at 5");
        step(1'b0, 1'b1, 1'b0, "R2 nickel to 10");
        step(1'b0, 1'b1, 1'b0, "R4 third nickel");
        step(1'b0, 1'b0, 1'b0, "R6 strobe ends");

        // R4 nickel then dime
        step(1'b0, 1'b1, 1'b0, "R4 nickel");
        step(1'b0, 1'b0, 1'b1, "R4 dime completes");
        // R3 then R4 dime then nickel, back to back
        step(1'b0, 1'b0, 1'b1, "R3 dime at 0");
        idle(3, "R7 hold at 10");
        step(1'b0, 1'b1, 1'b0, "R4 nickel completes");

        // R5 overpay, then check nothing carried over
        step(1'b0, 1'b0, 1'b1, "R5 dime");
        step(1'b0, 1'b0, 1'b1, "R5 second dime");
        step(1'b0, 1'b1, 1'b0, "R5 no carry nickel");
        step(1'b0, 1'b1, 1'b0, "R5 no carry nickel 2");
        step(1'b0, 1'b1, 1'b0, "R5 vend after three");
        // R5 nickel nickel dime (20 cents)
        step(1'b0, 1'b1, 1'b0, "R5 n");
        step(1'b0, 1'b1, 1'b0, "R5 nn");
        step(1'b0, 1'b0, 1'b1, "R5 nnd overpay");

        // R8 illegal at each credit level
        step(1'b0, 1'b1, 1'b1, "R8 both at 0");
        step(1'b0, 1'b1, 1'b0, "R8 nickel");
        step(1'b0, 1'b1, 1'b1, "R8 both at 5");
        step(1'b0, 1'b1, 1'b0, "R8 nickel");
        step(1'b0, 1'b1, 1'b1, "R8 both at 10");
        step(1'b0, 1'b1, 1'b0, "R8 nickel completes");

        // R1 reset while holding credit
        step(1'b0, 1'b0, 1'b1, "R1 dime before reset");
        step(1'b1, 1'b0, 1'b0, "R1 reset clears");
        step(1'b0, 1'b1, 1'b0, "R1 nickel after reset");
        step(1'b0, 1'b0, 1'b1, "R1 dime completes");

        // random mix
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = $urandom_range(0, 9);
            if (sel == 0)      step(1'b1, 1'b0, 1'b0, "R1 random reset");
            else if (sel <= 3) step(1'b0, 1'b1, 1'b0, "R2 random nickel");
            else if (sel <= 5) step(1'b0, 1'b0, 1'b1, "R3 random dime");
            else if (sel == 6) step(1'b0, 1'b1, 1'b1, "R8 random both");
            else               step(1'b0, 1'b0, 1'b0, "R7 random idle");
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule